// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block receives 16-bit command words over a three-wire serial link: an active-low frame-select line, a serial clock and a data line. All three pins are brought into the system clock domain through two-flop synchronisers. The falling edges of the serial clock are then detected as single-cycle events. The system clock must run at least four times faster than the serial clock.

A frame opens when the synchronised frame-select line falls. While the line stays low, the data pin is sampled on each falling edge of the serial clock, most significant bit first. The sixteenth sample completes the word. At that point the word is presented on a parallel output with a strobe one cycle wide. Serial clocks that arrive later in the same frame are discarded. If frame-select returns high before the sixteenth edge, the partial word is dropped without trace. Decoding of the word is left to the logic downstream.

Top module: `frame_word_rx`

## Requirements
- R1: While reset is applied and after it is released, `word_valid` is 0 and `word_data` is 0 until the first complete frame.
- R2: A frame in which frame-select stays low for exactly 16 serial clock falling edges produces exactly one `word_valid` pulse. `word_data` then equals the 16 sampled data bits, with the first sample at bit 15 and the last at bit 0.
- R3: `word_valid` is high for exactly one system clock cycle per completed frame.
- R4: `word_valid` rises on the third rising system clock edge after the sixteenth serial falling edge appears on the pin (two synchroniser stages plus one output register).
- R5: Serial clock falling edges after the sixteenth one in the same frame produce no further pulse and leave `word_data` unchanged, until frame-select goes high and then low again.
- R6: If frame-select rises before the sixteenth falling edge, no pulse is produced and `word_data` keeps its previous value.
- R7: After an aborted or completed frame, the next frame starts counting from zero once frame-select has gone high and then low again.
- R8: Serial clock falling edges while frame-select is high are ignored. They produce no pulse and do not advance the bit count of the next frame.
- R9: `word_data` changes only in a cycle in which `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n_pin | input | 1 | Frame-select pin, active low |
| sck_pin | input | 1 | Serial clock pin; data is sampled on its falling edge |
| sdi_pin | input | 1 | Serial data pin |
| word_valid | output | 1 | One-cycle strobe marking a completed word |
| word_data | output | 16 | Last completed word |

## Verification
Random words are sent with frames of exactly sixteen clocks, with longer frames and with short frames. Comparing the pulse count and the word for these three cases separates correct framing from counting one edge too few or too many, and from an abort that fails to take effect. Directed cases cover the rest:
- all-zero and all-one words, which expose bit-order and stuck bits;
- serial clocks sent while frame-select is high, which must not shift the next frame;
- a short frame followed by a complete one, which shows that the bit count restarts.

The distance from the sixteenth edge to the strobe is measured in system cycles.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_HOLD  = 2'd2
  } rx_state_e;

  // positions of the pins inside the synchroniser vector
  localparam int unsigned PIN_SEL = 0;
  localparam int unsigned PIN_SCK = 1;
  localparam int unsigned PIN_SDI = 2;
  localparam int unsigned PIN_CNT = 3;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/frx_fall_det.sv
module frx_fall_det #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[b] <= RST_VAL[b];
      else        prev_q[b] <= lvl[b];
    end
    assign fall[b] = prev_q[b] & ~lvl[b];
  end
endmodule

// File: rtl/frx_core.sv
module frx_core
  import frame_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sel_fall,
  input  logic              sck_fall,
  input  logic              sdi_lvl,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              shift_en;
  logic [WORD_W-1:0] shifted;

  assign shifted = {shreg_q[WORD_W-2:0], sdi_lvl};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    word_d   = word_q;
    valid_d  = 1'b0;
    shift_en = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (sel_fall) begin
          state_d = RX_SHIFT;
          cnt_d   = '0;
        end
      end
      RX_SHIFT: begin
        if (sel_lvl) begin
          state_d = RX_IDLE;
        end else if (sck_fall) begin
          shift_en = 1'b1;
          shreg_d  = shifted;
          cnt_d    = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            valid_d = 1'b1;
            word_d  = shifted;
            state_d = RX_HOLD;
          end
        end
      end
      RX_HOLD: begin
        if (sel_lvl) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      if (shift_en) shreg_q <= shreg_d;
      if (valid_d)  word_q  <= word_d;
    end
  end

  assign word_valid = valid_q;
  assign word_data  = word_q;
endmodule

// File: rtl/frame_word_rx.sv
module frame_word_rx
  import frame_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_pin,
  input  logic              sck_pin,
  input  logic              sdi_pin,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam logic [PIN_CNT-1:0] PIN_RST = 3'b011; // sel high, sck high, sdi low

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic [1:0]         falls;
  logic               sel_lvl, sck_lvl, sdi_lvl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pins_raw[PIN_SEL] = sel_n_pin;
  assign pins_raw[PIN_SCK] = sck_pin;
  assign pins_raw[PIN_SDI] = sdi_pin;

  frx_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
    .clk(clk), .rst_n(rst_int_n), .din(pins_raw), .dout(pins_s)
  );

  assign sel_lvl = pins_s[PIN_SEL];
  assign sck_lvl = pins_s[PIN_SCK];
  assign sdi_lvl = pins_s[PIN_SDI];

  frx_fall_det #(.WIDTH(2), .RST_VAL(2'b11)) i_fall (
    .clk(clk), .rst_n(rst_int_n), .lvl({sck_lvl, sel_lvl}), .fall(falls)
  );

  frx_core #(.WORD_W(WORD_W)) i_core (
    .clk(clk), .rst_n(rst_int_n),
    .sel_lvl(sel_lvl), .sel_fall(falls[0]), .sck_fall(falls[1]),
    .sdi_lvl(sdi_lvl),
    .word_valid(word_valid), .word_data(word_data)
  );
endmodule

// File: rtl/frame_word_rx_chk.sv
module frame_word_rx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_lvl,
  input logic              sck_lvl,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data
);
  localparam int unsigned CW = $clog2(WORD_W + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic          sck_prev_q;
  logic [CW-1:0] fall_cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b1;
      fall_cnt_q <= '0;
      done_q     <= 1'b0;
    end else begin
      sck_prev_q <= sck_lvl;
      if (sel_lvl) fall_cnt_q <= '0;
      else if (sck_prev_q && !sck_lvl && fall_cnt_q != CMAX) fall_cnt_q <= fall_cnt_q + 1'b1;
      if (sel_lvl) done_q <= 1'b0;
      else if (word_valid) done_q <= 1'b1;
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!word_valid);
    end
  end

  // R2
  sixteen_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> fall_cnt_q == CW'(WORD_W));

  // R3
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R5
  single_word_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !word_valid);

  // R6
  no_pulse_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !$past(sel_lvl));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));
endmodule

bind frame_word_rx frame_word_rx_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sel_lvl(sel_lvl), .sck_lvl(sck_lvl),
  .word_valid(word_valid), .word_data(word_data)
);

// File: tb/test_frame_word_rx.sv
module test_frame_word_rx;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk, rst_n, sel_n, sck, sdi;
  logic         word_valid;
  logic [W-1:0] word_data;

  int checks, failures;
  int cyc, pulses, valid_cyc, fall_cyc;
  logic [W-1:0] cap_word, exp_word;
  logic prev_valid;
  int wide_seen;
  bit finished;

  frame_word_rx i_frame_word_rx (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sck_pin(sck), .sdi_pin(sdi),
    .word_valid(word_valid), .word_data(word_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (word_valid) begin
      pulses    <= pulses + 1;
      cap_word  <= word_data;
      valid_cyc <= cyc;
      if (prev_valid) wide_seen <= wide_seen + 1;
    end
    prev_valid <= word_valid;
  end

  function automatic int exp_pulses(int nfalls, bit aborted);
    return (!aborted && nfalls >= W) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic one_fall(bit b, bit record);
    sdi = b;
    @(negedge clk);
    sck = 1'b0;
    if (record) fall_cyc = cyc;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    @(negedge clk);
  endtask

  // nfalls edges; bits beyond the word are random filler
  task automatic frame(logic [W-1:0] w, int nfalls, string req);
    int p0 = pulses;
    int e = exp_pulses(nfalls, 1'b0);
    sel_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nfalls; i++)
      one_fall(i < W ? w[W-1-i] : 1'($urandom), i == W-1);
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
    check(pulses - p0 == e, req, pulses - p0, e);
    if (e == 1) begin
      exp_word = w;
      check(valid_cyc - fall_cyc == 3, "R4", valid_cyc - fall_cyc, 3);
    end
    check(word_data == exp_word, req, word_data, exp_word);
  endtask

  initial begin
    int seed;
    checks = 0; failures = 0; cyc = 0; pulses = 0; wide_seen = 0;
    prev_valid = 1'b0; exp_word = '0; finished = 0;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; sel_n = 1'b1; sck = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    check(word_valid == 1'b0 && word_data == '0, "R1", word_data, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(word_valid == 1'b0 && word_data == '0, "R1", word_data, 0);
    check(pulses == 0, "R1", pulses, 0);

    // directed corners
    frame(16'hA5C3, 16, "R2");
    frame(16'h0000, 16, "R2");
    frame(16'hFFFF, 16, "R2");
    frame(16'h8001, 16, "R2");
    frame(16'h1234, 21, "R5");          // extra clocks ignored
    frame(16'h5A5A, 9, "R6");           // short frame aborted
    frame(16'h7E81, 15, "R6");          // one edge short
    frame(16'h3C3C, 16, "R7");          // count restarted after abort

    // R8: clocks with frame-select high
    for (int i = 0; i < 5; i++) one_fall(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(word_data == exp_word, "R8", word_data, exp_word);
    frame(16'h0F0F, 16, "R8");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] w = W'($urandom);
      int kind = $urandom_range(0, 2);
      int nf = (kind == 0) ? 16 : (kind == 1) ? $urandom_range(17, 22) : $urandom_range(1, 15);
      frame(w, nf, kind == 2 ? "R6" : (kind == 1 ? "R5" : "R2"));
    end

    check(wide_seen == 0, "R3", wide_seen, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule